// File: doc/BRIEF.md
# Serial I/Q Sample Serializer with Strobe

This block sits on the baseband side of a serial sample link. It takes parallel I/Q sample pairs through a valid/ready handshake and shifts them out one bit per bit-rate clock-enable tick. The bits go out on two lanes (I and Q side by side) or on one lane (both words in turn). A framing strobe is produced alongside the data and is locked to the bit counter. Between samples, with nothing to send, both lanes and the strobe sit low.

The word width is 16 or 12 bits. In the narrow mode only the top twelve bits of each 16-bit input word are sent. Bit order, word order (single-lane only), lane mode and strobe shape are all sampled when a pair is accepted. They stay fixed for the whole of that sample, so a configuration change takes effect only at a sample boundary. Ready rises during the last bit period of the current sample, so a producer that keeps valid high gets a gap-free stream.

Top module: `iq_serializer`

## Requirements
- R1: In dual-lane mode (cfg_single_lane=0) the I word goes out on lane_a and the Q word on lane_b, one bit per cycle with bit_en high. The first bit is visible in the cycle after the accepting edge.
- R2: With cfg_lsb_first=0 a word is sent from bit 15 downward. With cfg_lsb_first=1 it is sent from the lowest transmitted bit upward.
- R3: With cfg_narrow=1 only bits [15:4] of each word are sent (12 bit periods per word) and bits [3:0] never appear. With cfg_narrow=0 all 16 bits are sent.
- R4: In single-lane mode (cfg_single_lane=1) both words go out back to back on lane_a and lane_b stays low. cfg_q_first=1 sends Q before I, and cfg_q_first=0 sends I first.
- R5: With cfg_half_strobe=0 the strobe is high for exactly the first bit period of each sample.
- R6: With cfg_half_strobe=1 the strobe is high for the first half of the sample's bit periods and low for the rest (8+8 at 16 bits dual-lane, 6+6 at 12 bits, W+W single-lane).
- R7: in_ready is high when idle and during the last bit period of a sample, and low otherwise. A pair offered during the last bit period starts with no gap bit.
- R8: With no sample in progress, lane_a, lane_b and strobe are low.
- R9: Configuration inputs are sampled only when a pair is accepted. Changing them mid-sample has no effect on that sample.
- R10: While bit_en is low the outputs hold and no pair is accepted.
- R11: After reset the lanes and strobe are low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Bit-rate clock enable |
| cfg_narrow | input | 1 | 1: 12-bit words, 0: 16-bit |
| cfg_lsb_first | input | 1 | 1: least significant sent bit first |
| cfg_single_lane | input | 1 | 1: both words on lane_a |
| cfg_q_first | input | 1 | Single-lane word order, 1: Q first |
| cfg_half_strobe | input | 1 | 1: half-duration strobe, 0: one-bit pulse |
| in_valid | input | 1 | Sample pair offered |
| in_i | input | 16 | I word |
| in_q | input | 16 | Q word |
| in_ready | output | 1 | Pair can be taken this bit period |
| lane_a | output | 1 | Serial lane for I, or both words |
| lane_b | output | 1 | Serial lane for Q |
| strobe | output | 1 | Framing strobe |

## Verification
The hardest case to reach from the ports is the hand-over between two samples. The next pair must be accepted in the same bit period as the previous sample's last bit. That pair also carries a different configuration, and the old configuration must still govern the final bit. The bench keeps valid high with the second pair from the cycle after the first acceptance. It counts the cycles in which ready stays low, then checks that the very next bit period shows bit 0 of the new pair with the strobe raised. Stalls of bit_en in the middle of a word and flipped configuration inputs during every sample cover the hold and latch rules.

// File: rtl/iq_serializer.sv
module iq_serializer #(
  parameter int WORD_W   = 16,
  parameter int NARROW_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              cfg_narrow,
  input  logic              cfg_lsb_first,
  input  logic              cfg_single_lane,
  input  logic              cfg_q_first,
  input  logic              cfg_half_strobe,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_i,
  input  logic [WORD_W-1:0] in_q,
  output logic              in_ready,
  output logic              lane_a,
  output logic              lane_b,
  output logic              strobe
);
  localparam int CNT_W = $clog2(2 * WORD_W);
  localparam int PW    = $clog2(WORD_W);
  localparam int PAD   = WORD_W - NARROW_W;

  logic              active;
  logic [CNT_W-1:0]  idx;
  logic [WORD_W-1:0] wi, wq;
  logic              c_narrow, c_lsb, c_single, c_qfirst, c_half;

  logic [CNT_W:0] wlen, nbits, idx_x;
  logic           last, take, second;
  logic [PW-1:0]  b, pos;
  logic [WORD_W-1:0] word_a;

  assign idx_x  = {1'b0, idx};
  assign wlen   = c_narrow ? (CNT_W+1)'(NARROW_W) : (CNT_W+1)'(WORD_W);
  assign nbits  = c_single ? (wlen << 1) : wlen;
  assign last   = active && (idx_x == nbits - 1'b1);
  assign in_ready = !active || last;
  assign take   = in_valid && in_ready && bit_en;

  assign second = c_single && (idx_x >= wlen);
  assign b      = second ? PW'(idx_x - wlen) : PW'(idx_x);
  assign pos    = c_lsb ? PW'((c_narrow ? PAD : 0) + int'(b)) : PW'(WORD_W - 1) - b;
  assign word_a = (c_single && (c_qfirst ^ second)) ? wq : wi;

  assign lane_a = active && word_a[pos];
  assign lane_b = active && !c_single && wq[pos];
  assign strobe = active && (c_half ? (idx_x < (nbits >> 1)) : (idx == '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      idx      <= '0;
      wi       <= '0;
      wq       <= '0;
      c_narrow <= 1'b0;
      c_lsb    <= 1'b0;
      c_single <= 1'b0;
      c_qfirst <= 1'b0;
      c_half   <= 1'b0;
    end else if (bit_en) begin
      if (take) begin
        active   <= 1'b1;
        idx      <= '0;
        wi       <= in_i;
        wq       <= in_q;
        c_narrow <= cfg_narrow;
        c_lsb    <= cfg_lsb_first;
        c_single <= cfg_single_lane;
        c_qfirst <= cfg_q_first;
        c_half   <= cfg_half_strobe;
      end else if (last) begin
        active <= 1'b0;
        idx    <= '0;
      end else if (active) begin
        idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/iq_serializer_chk.sv
module iq_serializer_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic in_valid,
  input logic in_ready,
  input logic lane_a,
  input logic lane_b,
  input logic strobe,
  input logic active,
  input logic c_single,
  input logic c_half
);
  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (!lane_a && !lane_b && !strobe));
  // R7
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> in_ready);
  // R10
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable({lane_a, lane_b, strobe}));
  // R4
  single_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && c_single) |-> !lane_b);
  // R5
  short_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !c_half && bit_en) |=> !strobe);
  // R6
  strobe_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe) |-> $past(in_valid && in_ready && bit_en));
endmodule

bind iq_serializer iq_serializer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .in_valid(in_valid),
  .in_ready(in_ready), .lane_a(lane_a), .lane_b(lane_b), .strobe(strobe),
  .active(active), .c_single(c_single), .c_half(c_half)
);

// File: tb/sim_iq_serializer.sv
module sim_iq_serializer;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, bit_en = 1;
  logic cfg_narrow = 0, cfg_lsb_first = 0, cfg_single_lane = 0, cfg_q_first = 0, cfg_half_strobe = 0;
  logic in_valid = 0;
  logic [15:0] in_i = 0, in_q = 0;
  logic in_ready, lane_a, lane_b, strobe;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  iq_serializer u0 (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .cfg_narrow(cfg_narrow),
    .cfg_lsb_first(cfg_lsb_first), .cfg_single_lane(cfg_single_lane),
    .cfg_q_first(cfg_q_first), .cfg_half_strobe(cfg_half_strobe),
    .in_valid(in_valid), .in_i(in_i), .in_q(in_q), .in_ready(in_ready),
    .lane_a(lane_a), .lane_b(lane_b), .strobe(strobe)
  );

  // {narrow, lsb_first, single_lane, q_first, half_strobe, i, q}
  localparam logic [36:0] VEC [8] = '{
    {5'b00000, 16'hA5C3, 16'h3C5A},
    {5'b01001, 16'h8001, 16'h7FFE},
    {5'b10000, 16'hFFF0, 16'h000F},
    {5'b11001, 16'h1234, 16'hABCD},
    {5'b00100, 16'hC0DE, 16'hBEEF},
    {5'b00110, 16'hF00D, 16'h0FF0},
    {5'b10101, 16'h9876, 16'h5432},
    {5'b11111, 16'h4321, 16'hFEDC}
  };

  task automatic chk(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  function automatic int wlen(input logic [36:0] v);
    return v[36] ? 12 : 16;
  endfunction

  function automatic int nbits(input logic [36:0] v);
    return v[34] ? 2 * wlen(v) : wlen(v);
  endfunction

  function automatic logic ref_bit(input logic [36:0] v, input int k, input int lane);
    int w = wlen(v);
    int b;
    logic [15:0] wd;
    if (v[34]) begin
      if (lane == 1) return 1'b0;
      wd = ((k < w) ^ v[33]) ? v[31:16] : v[15:0];
      b = k % w;
    end else begin
      wd = lane == 1 ? v[15:0] : v[31:16];
      b = k;
    end
    return v[35] ? wd[(16 - w) + b] : wd[15 - b];
  endfunction

  function automatic logic ref_strobe(input logic [36:0] v, input int k);
    return v[32] ? (k < nbits(v) / 2) : (k == 0);
  endfunction

  task automatic drive(input logic [36:0] v);
    {cfg_narrow, cfg_lsb_first, cfg_single_lane, cfg_q_first, cfg_half_strobe} = v[36:32];
    in_i = v[31:16];
    in_q = v[15:0];
  endtask

  task automatic check_bit(input logic [36:0] v, input int k);
    chk(lane_a, ref_bit(v, k, 0), v[34] ? "R4 lane_a" : (v[36] ? "R3 lane_a" : "R1/R2 lane_a"));
    chk(lane_b, ref_bit(v, k, 1), v[34] ? "R4 lane_b" : "R1/R2 lane_b");
    chk(strobe, ref_strobe(v, k), v[32] ? "R6 strobe" : "R5 strobe");
    chk(in_ready, k == nbits(v) - 1, "R7 ready");
  endtask

  task automatic xmit(input logic [36:0] v, input bit stall);
    @(negedge clk);
    drive(v);
    in_valid = 1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
    {cfg_narrow, cfg_lsb_first, cfg_single_lane, cfg_q_first, cfg_half_strobe} = ~v[36:32]; // R9
    in_i = ~v[31:16];
    in_q = ~v[15:0];
    for (int k = 0; k < nbits(v); k++) begin
      check_bit(v, k);
      if (stall && k == 3) begin
        bit_en = 0;
        for (int s = 0; s < 2; s++) begin
          @(negedge clk);
          check_bit(v, k); // R10 outputs hold
        end
        bit_en = 1;
      end
      @(negedge clk);
    end
    chk(lane_a, 1'b0, "R8 idle lane_a");
    chk(lane_b, 1'b0, "R8 idle lane_b");
    chk(strobe, 1'b0, "R8 idle strobe");
    chk(in_ready, 1'b1, "R7 idle ready");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [36:0] va, vb;
    #(CLK_PERIOD * 3);
    @(negedge clk);
    chk(lane_a, 1'b0, "R11 reset lane_a");
    chk(lane_b, 1'b0, "R11 reset lane_b");
    chk(strobe, 1'b0, "R11 reset strobe");
    chk(in_ready, 1'b1, "R11 reset ready");
    rst_n = 1;

    for (int n = 0; n < 8; n++) xmit(VEC[n], 1'b0);

    xmit(VEC[0], 1'b1);
    xmit(VEC[6], 1'b1);

    // R10: no acceptance while bit_en is low
    @(negedge clk);
    drive(VEC[1]);
    bit_en = 0;
    in_valid = 1;
    @(negedge clk);
    @(negedge clk);
    chk(strobe, 1'b0, "R10 no accept strobe");
    chk(lane_a, 1'b0, "R10 no accept lane_a");
    in_valid = 0;
    bit_en = 1;

    // R7/R9: back-to-back samples with differing configuration
    va = VEC[2];
    vb = VEC[5];
    @(negedge clk);
    drive(va);
    in_valid = 1;
    @(negedge clk);
    drive(vb);
    for (int k = 0; k < nbits(va); k++) begin
      check_bit(va, k);
      @(negedge clk);
    end
    in_valid = 0;
    chk(strobe, 1'b1, "R7 no gap strobe");
    for (int k = 0; k < nbits(vb); k++) begin
      check_bit(vb, k);
      @(negedge clk);
    end
    chk(lane_a, 1'b0, "R8 idle after stream");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule